// File: doc/BRIEF.md
# Synchronous Data Escape Packer

This block sits in the transmit data path of a modem-style link that carries synchronous payload over a character-oriented, asynchronous host channel. Four byte values carry meaning on that channel: the escape character 0x19, its high-bit twin 0x99, and the two software flow-control characters XON (0x11) and XOFF (0x13). The block replaces each of them with the escape character followed by a code byte, so the payload never shows a raw control character.

Two reserved bytes in a row cost only two output bytes, because the block looks one byte ahead. When a reserved byte arrives, it is parked for a cycle. If the next byte is also reserved, both go out as one escape plus a pair code. If the next byte is an ordinary byte, or the `flush` input is raised, the parked byte goes out alone as an escape plus a single code. Both sides are byte streams with valid/ready handshakes. Frame delimiting and checksum generation belong to other blocks.

Top module: `sync_escape_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A byte other than 0x19, 0x99, 0x11 or 0x13 is emitted once, unchanged, and bytes leave in the order they were accepted. A lone byte at the output is never one of the four reserved values.
- R3: A reserved byte sent on its own becomes 0x19 followed by a code: 0x19 gives 0x5C, 0x99 gives 0x76, 0x11 gives 0xA0 and 0x13 gives 0xA1. The byte after an escape on the output always lies in 0x5C–0x5D, 0x76–0x77 or 0xA0–0xAF.
- R4: Two equal reserved bytes in a row become 0x19 followed by one code: 0x19 0x19 gives 0x5D, 0x99 0x99 gives 0x77, 0x11 0x11 gives 0xA2 and 0x13 0x13 gives 0xA3.
- R5: Two different reserved bytes in a row (with PAIR_EN=1) become 0x19 and one code. Rank the reserved bytes 0x19, 0x99, 0x11, 0x13. The codes 0xA4 to 0xAF are then handed out in increasing order over the twelve ordered pairs, sorted first by the first byte's rank and then by the second's. For example, 0x19 0x99 gives 0xA4, 0x99 0x19 gives 0xA7, 0x11 0x13 gives 0xAC and 0x13 0x11 gives 0xAF.
- R6: A parked reserved byte followed by an ordinary byte is emitted as its single code, ahead of that ordinary byte. `in_ready` is low during the cycle that releases it.
- R7: While `flush` is high, a parked byte is released as its single code in the next cycle in which the output can take it. A reserved byte accepted while `flush` is high is coded as single at once and is not parked.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. `in_ready` is low whenever the two-byte output stage cannot take new output.
- R9: Decoding the output stream with the same code table gives back exactly the accepted input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when high with in_valid |
| flush | input | 1 | Release a parked byte without waiting for a partner |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The bench builds the packer with PAIR_EN=1 and the escape at its default of 0x19. With these values all four single codes and all sixteen ordered pair codes can be reached. The directed phases drive every one of the twenty codes. A long random phase then mixes a reserved-heavy input with random output stalls and random flush pulses. This covers the cases where a parked byte, a full output stage and a flush meet in the same cycle. A behavioural model kept in queues predicts `in_ready`, `out_valid` and `out_data` every clock. A decoder in the bench rebuilds the input from the output stream.

// File: rtl/sync_escape_packer.sv
module sync_escape_packer #(
  parameter bit         PAIR_EN = 1'b1,
  parameter logic [7:0] ESC     = 8'h19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       flush,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam logic [7:0] HI  = ESC | 8'h80;
  localparam logic [7:0] XON = 8'h11;
  localparam logic [7:0] XOF = 8'h13;

  function automatic logic is_res(input logic [7:0] b);
    return (b == ESC) || (b == HI) || (b == XON) || (b == XOF);
  endfunction

  function automatic logic [1:0] rank(input logic [7:0] b);
    if (b == ESC) return 2'd0;
    if (b == HI)  return 2'd1;
    if (b == XON) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [7:0] one_code(input logic [1:0] r);
    case (r)
      2'd0:    return 8'h5C;
      2'd1:    return 8'h76;
      2'd2:    return 8'hA0;
      default: return 8'hA1;
    endcase
  endfunction

  function automatic logic [7:0] two_code(input logic [1:0] a, input logic [1:0] b);
    logic [7:0] col;
    if (a == b) begin
      case (a)
        2'd0:    return 8'h5D;
        2'd1:    return 8'h77;
        2'd2:    return 8'hA2;
        default: return 8'hA3;
      endcase
    end
    col = (b < a) ? {6'd0, b} : ({6'd0, b} - 8'd1);
    return 8'hA4 + {6'd0, a} * 8'd3 + col;
  endfunction

  logic       hold_v;
  logic [7:0] hold_b;
  logic [1:0] ob_cnt;
  logic [7:0] ob0, ob1;

  logic room, in_res, take, park, rel_pair, rel_one, esc_in, plain_in;

  assign room     = (ob_cnt == 2'd0) || (ob_cnt == 2'd1 && out_ready);
  assign in_res   = is_res(in_data);
  assign in_ready = room && (!hold_v || (in_res && !flush));
  assign take     = in_valid && in_ready;
  assign rel_pair = hold_v && take;
  assign rel_one  = hold_v && !take && room && (flush || in_valid);
  assign park     = !hold_v && take && in_res && PAIR_EN && !flush;
  assign esc_in   = !hold_v && take && in_res && !park;
  assign plain_in = !hold_v && take && !in_res;

  assign out_valid = (ob_cnt != 2'd0);
  assign out_data  = ob0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_b <= 8'h00;
      ob_cnt <= 2'd0;
      ob0    <= 8'h00;
      ob1    <= 8'h00;
    end else begin
      if (park) begin
        hold_v <= 1'b1;
        hold_b <= in_data;
      end else if (rel_pair || rel_one) begin
        hold_v <= 1'b0;
      end

      if (rel_pair) begin
        ob_cnt <= 2'd2;
        ob0    <= ESC;
        ob1    <= two_code(rank(hold_b), rank(in_data));
      end else if (rel_one) begin
        ob_cnt <= 2'd2;
        ob0    <= ESC;
        ob1    <= one_code(rank(hold_b));
      end else if (esc_in) begin
        ob_cnt <= 2'd2;
        ob0    <= ESC;
        ob1    <= one_code(rank(in_data));
      end else if (plain_in) begin
        ob_cnt <= 2'd1;
        ob0    <= in_data;
      end else if (out_valid && out_ready) begin
        ob_cnt <= ob_cnt - 2'd1;
        ob0    <= ob1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  AST_FULL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ob_cnt == 2'd2 |-> !in_ready); // R8

  AST_CODE_AFTER_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && ob_cnt == 2'd2 |=>
      out_valid && ((out_data inside {8'h5C, 8'h5D, 8'h76, 8'h77}) ||
                    (out_data >= 8'hA0 && out_data <= 8'hAF))); // R3

  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && flush && room |=> ob_cnt == 2'd2 && ob0 == ESC && !hold_v); // R7

  AST_LONE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ob_cnt == 2'd1 |-> !is_res(out_data)); // R2

  AST_RELEASE_BEFORE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && in_valid && !is_res(in_data) |-> !in_ready); // R6
endmodule

// File: tb/sync_escape_packer_tb.sv
module sync_escape_packer_tb;
  localparam bit PAIR = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  sync_escape_packer #(.PAIR_EN(PAIR), .ESC(8'h19)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flush(flush), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready));

  int checks = 0, fails = 0;
  string tag = "R1";
  int mh = -1;
  logic [7:0] mq[$];
  logic [7:0] sent[$];
  logic [7:0] got[$];
  bit after_esc = 0;

  function automatic bit isres(logic [7:0] b);
    return b == 8'h19 || b == 8'h99 || b == 8'h11 || b == 8'h13;
  endfunction

  function automatic logic [7:0] scode(logic [7:0] b);
    case (b)
      8'h19: return 8'h5C;
      8'h99: return 8'h76;
      8'h11: return 8'hA0;
      default: return 8'hA1;
    endcase
  endfunction

  function automatic logic [7:0] pcode(logic [7:0] a, logic [7:0] b);
    case ({a, b})
      16'h1919: return 8'h5D; 16'h9999: return 8'h77;
      16'h1111: return 8'hA2; 16'h1313: return 8'hA3;
      16'h1999: return 8'hA4; 16'h1911: return 8'hA5; 16'h1913: return 8'hA6;
      16'h9919: return 8'hA7; 16'h9911: return 8'hA8; 16'h9913: return 8'hA9;
      16'h1119: return 8'hAA; 16'h1199: return 8'hAB; 16'h1113: return 8'hAC;
      16'h1319: return 8'hAD; 16'h1399: return 8'hAE;
      default:  return 8'hAF;
    endcase
  endfunction

  task automatic decode(logic [7:0] c);
    case (c)
      8'h5C: got.push_back(8'h19);
      8'h76: got.push_back(8'h99);
      8'hA0: got.push_back(8'h11);
      8'hA1: got.push_back(8'h13);
      default: begin
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            logic [7:0] x, y;
            x = (a == 0) ? 8'h19 : (a == 1) ? 8'h99 : (a == 2) ? 8'h11 : 8'h13;
            y = (b == 0) ? 8'h19 : (b == 1) ? 8'h99 : (b == 2) ? 8'h11 : 8'h13;
            if (pcode(x, y) == c) begin
              got.push_back(x);
              got.push_back(y);
            end
          end
      end
    endcase
  endtask

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] d, logic fl, logic ordy, output bit took);
    bit room, ires, er, ev, fire_o, tk;
    @(negedge clk);
    in_valid = v; in_data = d; flush = fl; out_ready = ordy;
    #1;
    room = (mq.size() == 0) || (mq.size() == 1 && ordy);
    ires = isres(d);
    er = room && (mh < 0 || (ires && !fl));
    ev = mq.size() != 0;
    check("in_ready", {7'd0, in_ready}, {7'd0, er});
    check("out_valid", {7'd0, out_valid}, {7'd0, ev});
    if (ev) check("out_data", out_data, mq[0]);
    fire_o = ev && ordy;
    tk = v && er;
    took = tk;
    @(posedge clk);
    if (fire_o) begin
      logic [7:0] ob;
      ob = mq.pop_front();
      if (after_esc) begin decode(ob); after_esc = 0; end
      else if (ob == 8'h19) after_esc = 1;
      else got.push_back(ob);
    end
    if (tk) sent.push_back(d);
    if (mh >= 0) begin
      if (tk) begin
        mq.push_back(8'h19); mq.push_back(pcode(mh[7:0], d)); mh = -1;
      end else if (room && (fl || v)) begin
        mq.push_back(8'h19); mq.push_back(scode(mh[7:0])); mh = -1;
      end
    end else if (tk) begin
      if (ires && PAIR && !fl) mh = int'(d);
      else if (ires) begin mq.push_back(8'h19); mq.push_back(scode(d)); end
      else mq.push_back(d);
    end
  endtask

  task automatic send(logic [7:0] d, logic fl);
    bit t;
    t = 0;
    while (!t) step(1'b1, d, fl, 1'b1, t);
  endtask

  task automatic idle(int n, logic fl);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, fl, 1'b1, t);
  endtask

  function automatic logic [7:0] resv(int k);
    return (k == 0) ? 8'h19 : (k == 1) ? 8'h99 : (k == 2) ? 8'h11 : 8'h13;
  endfunction

  task automatic run_all();
    bit t;
    logic [7:0] cur;
    bit have;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R1";
    check("reset out_valid", {7'd0, out_valid}, 8'd0);
    check("reset in_ready", {7'd0, in_ready}, 8'd1);

    tag = "R2";
    for (int i = 0; i < 6; i++) send(8'h30 + 8'(i * 37), 1'b0);
    idle(3, 1'b0);

    tag = "R3";
    for (int k = 0; k < 4; k++) begin send(resv(k), 1'b0); send(8'h41, 1'b0); end
    idle(4, 1'b0);

    tag = "R4";
    for (int k = 0; k < 4; k++) begin send(resv(k), 1'b0); send(resv(k), 1'b0); idle(3, 1'b0); end

    tag = "R5";
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) begin send(resv(a), 1'b0); send(resv(b), 1'b0); idle(3, 1'b0); end

    tag = "R6";
    send(8'h99, 1'b0); send(8'h00, 1'b0); send(8'h13, 1'b0); send(8'hFF, 1'b0);
    idle(4, 1'b0);

    tag = "R7";
    send(8'h11, 1'b0); idle(2, 1'b0); idle(1, 1'b1); idle(3, 1'b0);
    send(8'h19, 1'b1); send(8'h99, 1'b1); idle(4, 1'b0);
    send(8'h13, 1'b0); send(8'h11, 1'b1); idle(4, 1'b0);

    tag = "R8";
    send(8'h19, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 8'h99, 1'b0, 1'b0, t);
    idle(4, 1'b0);
    have = 0; cur = 8'h00;
    for (int i = 0; i < 4000; i++) begin
      logic fl, ordy;
      if (!have && ($urandom % 4 != 0)) begin
        have = 1;
        cur = ($urandom % 2 == 0) ? resv(int'($urandom % 4)) : 8'($urandom);
      end
      fl = ($urandom % 8 == 0);
      ordy = ($urandom % 4 != 0);
      step(have, cur, fl, ordy, t);
      if (t) have = 0;
    end
    while (have) begin step(1'b1, cur, 1'b0, 1'b1, t); if (t) have = 0; end
    idle(2, 1'b1);
    idle(6, 1'b0);

    tag = "R9";
    check("decoded length", 8'(got.size()), 8'(sent.size()));
    for (int i = 0; i < sent.size() && i < got.size(); i++)
      check("decoded byte", got[i], sent[i]);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule